// File: doc/BRIEF.md
# ATA Task-File Command Issuer

This block starts one single-sector ATA command in LBA addressing mode on a CompactFlash or IDE device. It drives the device's task-file registers through a simple synchronous register port. A request carries a 28-bit logical block address, an 8-bit command code and a bus-mode select. The block first polls the status register until the busy flag drops. It then writes the sector count, the four address bytes (the top nibble is merged into the drive/head byte with the LBA and master-select bits) and the command code. Finally it polls status again until the device stops being busy.

Three register-access modes are supported. In the 8-bit direct mode each register is one byte location. In the packed 16-bit mode two adjacent registers share one 16-bit word, so the whole command goes out in three word writes. In the low-byte 16-bit mode each register occupies its own 16-bit word and only the low byte carries data. Each request ends with exactly one of three one-cycle outcomes: done, device fault, or absent (the device stayed busy before the command). Data transfer that follows the command belongs to another block.

Top module: `ata_cmd_issuer`

## Requirements
- R1: During and immediately after reset, `done_o`, `fault_o`, `absent_o`, `dev_rd_o` and `dev_wr_o` are all low.
- R2: After a request is accepted, the status register is read before any write. Each busy read (status bit 7 set) is followed by exactly `POLL_GAP` quiet cycles and then a new status read. No register write occurs while the last status seen is busy.
- R3: If `MAX_POLLS` consecutive status reads before the command all show busy, `absent_o` pulses after the last of them and no register is written.
- R4: With `mode_i` = 0 (8-bit direct), the port address is the byte offset of the register. Status and command are at 7 and status is taken from `dev_rdata_i[7:0]`. The writes are, in order: address 2 ← 0x01, 3 ← LBA[7:0], 4 ← LBA[15:8], 5 ← LBA[23:16], 6 ← {4'hE, LBA[27:24]}, 7 ← command. The upper data byte is zero.
- R5: With `mode_i` = 2 (low-byte 16-bit), each register sits at port address 2 × its offset. The write order and byte values are those of R4, at addresses 4, 6, 8, 10, 12, 14, with the upper data byte zero. Status is read at address 14 from `dev_rdata_i[7:0]`.
- R6: With `mode_i` = 1 or 3 (packed 16-bit), exactly three writes occur: address 2 ← {LBA[7:0], 8'h01}, address 4 ← {LBA[23:16], LBA[15:8]}, address 6 ← {command, 4'hE, LBA[27:24]}. Status is read at address 6 from `dev_rdata_i[15:8]`.
- R7: After the command write, a status read showing busy with the fault bit (bit 5) set ends the request with `fault_o`. A read showing busy clear ends it with `done_o`, whatever bits 5 and 3 show.
- R8: Each request ends with exactly one outcome pulse, one cycle long. Let P = POLL_GAP + 2, b the busy reads before the command, q the busy reads after it, and W the write count (6 or 3). Counted in rising edges after the edge that accepts the request, the outcome is visible after edge b·P + 2 + W + q·P + 2 for done. It is visible after b·P + 2 + W + 2 for fault on the first post-command read, and after (MAX_POLLS−1)·P + 2 for absent.
- R9: `start_i` is ignored while a request is in progress, and the address and command latched at acceptance are the ones written. A `start_i` in the cycle where an outcome pulses is accepted.
- R10: Read data is taken in the cycle after the read strobe. A read strobe never lasts two consecutive cycles, and every outcome follows a read strobe by two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request a command; taken only when idle |
| lba_i | input | 28 | Logical block address of the sector |
| cmd_i | input | 8 | ATA command code (e.g. 0x20 read, 0x30 write, 0xEC identify) |
| mode_i | input | 2 | Register-access mode: 0 direct byte, 1/3 packed word, 2 low-byte word |
| done_o | output | 1 | One-cycle pulse: command finished, device no longer busy |
| fault_o | output | 1 | One-cycle pulse: device fault reported while busy |
| absent_o | output | 1 | One-cycle pulse: device stayed busy for the whole presence window |
| dev_addr_o | output | 4 | Register port byte address |
| dev_wr_o | output | 1 | Register write strobe |
| dev_wdata_o | output | 16 | Register write data |
| dev_rd_o | output | 1 | Register read strobe |
| dev_rdata_i | input | 16 | Register read data, valid the cycle after `dev_rd_o` |

## Verification
Two events can share one cycle. A new request can arrive in the same cycle an outcome pulses. The bench raises `start_i` at the sample point where `done_o` is seen, then judges the second request by its own write log and latency. The fault and busy-clear conditions can also share one status byte. The device model returns status with busy clear and the fault bit set, and the bench expects `done_o`, not `fault_o`. A second start pulsed mid-request is checked against the write log to confirm that the original address survived.

// File: rtl/ata_cmd_pkg.sv
// Package: shared encodings for the ATA task-file command issuer.
// Assumes task-file register offsets and status bit positions of a
// standard ATA device; these are fixed by the device, not tunable.
package ata_cmd_pkg;

    // Register-access modes of the device port
    typedef enum logic [1:0] {
        BUS_BYTE8  = 2'd0,
        BUS_PACK16 = 2'd1,
        BUS_LOW16  = 2'd2,
        BUS_RSVD   = 2'd3
    } bus_mode_e;

    // Task-file byte offsets the sequence touches
    localparam logic [2:0] OFF_SECCNT = 3'd2;
    localparam logic [2:0] OFF_LBA0   = 3'd3;
    localparam logic [2:0] OFF_LBA1   = 3'd4;
    localparam logic [2:0] OFF_LBA2   = 3'd5;
    localparam logic [2:0] OFF_DEVSEL = 3'd6;
    localparam logic [2:0] OFF_CMDSTS = 3'd7;

    // Status bit positions
    localparam int STS_BUSY  = 7;
    localparam int STS_FAULT = 5;

    // Upper nibble of the drive/head byte: LBA addressing, master
    localparam logic [3:0] DEVSEL_HI = 4'hE;

    // Controller states
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE_RD,
        ST_PRE_WT,
        ST_PRE_GAP,
        ST_WRITE,
        ST_POST_RD,
        ST_POST_WT,
        ST_POST_GAP
    } issuer_state_e;

    // Packed word mode is the fallback for the spare encoding
    function automatic logic mode_is_packed(input logic [1:0] m);
        return (m == BUS_PACK16) || (m == BUS_RSVD);
    endfunction

endpackage

// File: rtl/ata_poll_gap.sv
// Module: quiet-interval timer between status polls.
// Loaded when a busy status is seen; gap_done rises in the last of
// GAP cycles. Assumes GAP >= 1.
module ata_poll_gap #(
    parameter int GAP = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic gap_done
);
    localparam int CW = (GAP < 2) ? 1 : $clog2(GAP + 1);

    logic [CW-1:0] cnt_q;

    // Count down from GAP-1 after each load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= CW'(GAP - 1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign gap_done = (cnt_q == '0);
endmodule

// File: rtl/ata_busy_tally.sv
// Module: counts consecutive busy status reads before the command.
// at_limit marks that the read being judged is the LIMIT-th busy one.
// Assumes LIMIT >= 1.
module ata_busy_tally #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic at_limit
);
    localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    // Clear on a new request, step on each busy read
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign at_limit = (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/ata_tf_encoder.sv
// Module: maps a write step to a port address and data word.
// Byte modes take six steps, packed word mode three; 'last' flags
// the step that carries the command code. Purely combinational.
module ata_tf_encoder
    import ata_cmd_pkg::*;
(
    input  logic [1:0]  mode,
    input  logic [2:0]  step,
    input  logic [27:0] lba,
    input  logic [7:0]  cmd,
    output logic [3:0]  addr,
    output logic [15:0] wdata,
    output logic        last
);
    logic [7:0] devsel;
    logic [2:0] off;
    logic [7:0] val;

    assign devsel = {DEVSEL_HI, lba[27:24]};

    // Select register and value for the current step
    always_comb begin
        addr  = '0;
        wdata = '0;
        last  = 1'b0;
        off   = OFF_SECCNT;
        val   = 8'h01;
        if (mode_is_packed(mode)) begin
            case (step)
                3'd0: begin
                    addr  = 4'd2;
                    wdata = {lba[7:0], 8'h01};
                end
                3'd1: begin
                    addr  = 4'd4;
                    wdata = {lba[23:16], lba[15:8]};
                end
                default: begin
                    addr  = 4'd6;
                    wdata = {cmd, devsel};
                    last  = 1'b1;
                end
            endcase
        end else begin
            case (step)
                3'd0: begin off = OFF_SECCNT; val = 8'h01;        end
                3'd1: begin off = OFF_LBA0;   val = lba[7:0];     end
                3'd2: begin off = OFF_LBA1;   val = lba[15:8];    end
                3'd3: begin off = OFF_LBA2;   val = lba[23:16];   end
                3'd4: begin off = OFF_DEVSEL; val = devsel;       end
                default: begin
                    off  = OFF_CMDSTS;
                    val  = cmd;
                    last = 1'b1;
                end
            endcase
            addr  = (mode == BUS_LOW16) ? {off, 1'b0} : {1'b0, off};
            wdata = {8'h00, val};
        end
    end
endmodule

// File: rtl/ata_status_lane.sv
// Module: locates the status register for a mode and extracts it.
// Packed word mode finds status in the upper byte of word 3; the
// byte modes find it in the low byte. Purely combinational.
module ata_status_lane
    import ata_cmd_pkg::*;
(
    input  logic [1:0]  mode,
    input  logic [15:0] rdata,
    output logic [3:0]  sts_addr,
    output logic [7:0]  sts
);
    // Address and byte lane of the status register
    always_comb begin
        if (mode_is_packed(mode)) begin
            sts_addr = 4'd6;
            sts      = rdata[15:8];
        end else if (mode == BUS_LOW16) begin
            sts_addr = {OFF_CMDSTS, 1'b0};
            sts      = rdata[7:0];
        end else begin
            sts_addr = {1'b0, OFF_CMDSTS};
            sts      = rdata[7:0];
        end
    end
endmodule

// File: rtl/ata_cmd_issuer.sv
// Module: top of the ATA task-file command issuer.
// Polls busy, writes the task file for one LBA sector command in the
// selected access mode, then polls busy to completion. Assumes the
// register port accepts one access per cycle and returns read data
// the cycle after the read strobe.
module ata_cmd_issuer
    import ata_cmd_pkg::*;
#(
    parameter int POLL_GAP  = 64,
    parameter int MAX_POLLS = 1000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic [27:0] lba_i,
    input  logic [7:0]  cmd_i,
    input  logic [1:0]  mode_i,
    output logic        done_o,
    output logic        fault_o,
    output logic        absent_o,
    output logic [3:0]  dev_addr_o,
    output logic        dev_wr_o,
    output logic [15:0] dev_wdata_o,
    output logic        dev_rd_o,
    input  logic [15:0] dev_rdata_i
);
    issuer_state_e state_q;
    logic [1:0]    mode_q;
    logic [27:0]   lba_q;
    logic [7:0]    cmd_q;
    logic [2:0]    step_q;
    logic          done_q, fault_q, absent_q;

    logic [3:0]    enc_addr;
    logic [15:0]   enc_wdata;
    logic          enc_last;
    logic [3:0]    sts_addr;
    logic [7:0]    sts;
    logic          sts_busy, sts_fault;
    logic          gap_load, gap_done;
    logic          tally_clr, tally_inc, tally_limit;
    logic          accept;
    logic          in_wait;

    ata_tf_encoder u_enc (
        .mode  (mode_q),
        .step  (step_q),
        .lba   (lba_q),
        .cmd   (cmd_q),
        .addr  (enc_addr),
        .wdata (enc_wdata),
        .last  (enc_last)
    );

    ata_status_lane u_lane (
        .mode     (mode_q),
        .rdata    (dev_rdata_i),
        .sts_addr (sts_addr),
        .sts      (sts)
    );

    ata_poll_gap #(.GAP(POLL_GAP)) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (gap_load),
        .gap_done (gap_done)
    );

    ata_busy_tally #(.LIMIT(MAX_POLLS)) u_tally (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (tally_clr),
        .inc      (tally_inc),
        .at_limit (tally_limit)
    );

    // Decode status and timer controls
    always_comb begin
        sts_busy  = sts[STS_BUSY];
        sts_fault = sts[STS_FAULT];
        accept    = (state_q == ST_IDLE) && start_i;
        in_wait   = (state_q == ST_PRE_WT) || (state_q == ST_POST_WT);
        gap_load  = in_wait && sts_busy;
        tally_clr = accept;
        tally_inc = (state_q == ST_PRE_WT) && sts_busy;
    end

    // Sequence polls, writes and outcome pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            mode_q   <= BUS_BYTE8;
            lba_q    <= '0;
            cmd_q    <= '0;
            step_q   <= '0;
            done_q   <= 1'b0;
            fault_q  <= 1'b0;
            absent_q <= 1'b0;
        end else begin
            done_q   <= 1'b0;
            fault_q  <= 1'b0;
            absent_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        mode_q  <= mode_i;
                        lba_q   <= lba_i;
                        cmd_q   <= cmd_i;
                        step_q  <= '0;
                        state_q <= ST_PRE_RD;
                    end
                end
                ST_PRE_RD: state_q <= ST_PRE_WT;
                ST_PRE_WT: begin
                    if (!sts_busy) begin
                        state_q <= ST_WRITE;
                    end else if (tally_limit) begin
                        absent_q <= 1'b1;
                        state_q  <= ST_IDLE;
                    end else begin
                        state_q <= ST_PRE_GAP;
                    end
                end
                ST_PRE_GAP: if (gap_done) state_q <= ST_PRE_RD;
                ST_WRITE: begin
                    if (enc_last) state_q <= ST_POST_RD;
                    else          step_q  <= step_q + 3'd1;
                end
                ST_POST_RD: state_q <= ST_POST_WT;
                ST_POST_WT: begin
                    if (!sts_busy) begin
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end else if (sts_fault) begin
                        fault_q <= 1'b1;
                        state_q <= ST_IDLE;
                    end else begin
                        state_q <= ST_POST_GAP;
                    end
                end
                ST_POST_GAP: if (gap_done) state_q <= ST_POST_RD;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Drive the register port from the current state
    always_comb begin
        dev_wr_o    = (state_q == ST_WRITE);
        dev_rd_o    = (state_q == ST_PRE_RD) || (state_q == ST_POST_RD);
        dev_addr_o  = dev_wr_o ? enc_addr : sts_addr;
        dev_wdata_o = dev_wr_o ? enc_wdata : 16'h0000;
    end

    assign done_o   = done_q;
    assign fault_o  = fault_q;
    assign absent_o = absent_q;
endmodule

// File: rtl/ata_cmd_issuer_chk.sv
// Module: property checker bound to the command issuer.
// Observes ports and the latched mode; drives nothing.
module ata_cmd_issuer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        done_o,
    input logic        fault_o,
    input logic        absent_o,
    input logic        dev_rd_o,
    input logic        dev_wr_o,
    input logic [15:0] dev_wdata_o,
    input logic [1:0]  mode_q
);
    logic any_end;
    assign any_end = done_o | fault_o | absent_o;

    // R8: at most one outcome at a time
    a_r8_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done_o, fault_o, absent_o}));

    // R8: outcomes last a single cycle
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        any_end |=> !any_end);

    // R10: a read strobe is followed by a cycle without one
    a_r10_read_gap: assert property (@(posedge clk) disable iff (!rst_n)
        dev_rd_o |=> !dev_rd_o);

    // R10: every outcome is decided from a read two cycles earlier
    a_r10_outcome_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        any_end |-> $past(dev_rd_o, 2));

    // R2: never a read and a write together
    a_r2_port_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dev_rd_o, dev_wr_o}));

    // R4 / R5: byte modes keep the upper data byte zero
    a_r5_upper_byte_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_wr_o && (mode_q == 2'd0 || mode_q == 2'd2)) |-> (dev_wdata_o[15:8] == 8'h00));
endmodule

bind ata_cmd_issuer ata_cmd_issuer_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .done_o      (done_o),
    .fault_o     (fault_o),
    .absent_o    (absent_o),
    .dev_rd_o    (dev_rd_o),
    .dev_wr_o    (dev_wr_o),
    .dev_wdata_o (dev_wdata_o),
    .mode_q      (mode_q)
);

// File: tb/ata_cmd_issuer_test.sv
// Bench: sweeps modes, busy lengths, commands and addresses against a
// scripted device model; expected writes and latencies are computed.
module ata_cmd_issuer_test;
    localparam int CLK_PERIOD = 10;
    localparam int PG = 3;
    localparam int MP = 4;
    localparam int PER = PG + 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [27:0] lba_i = '0;
    logic [7:0]  cmd_i = '0;
    logic [1:0]  mode_i = '0;
    logic        done_o, fault_o, absent_o;
    logic [3:0]  dev_addr_o;
    logic        dev_wr_o, dev_rd_o;
    logic [15:0] dev_wdata_o;
    logic [15:0] dev_rdata_i = '0;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ata_cmd_issuer #(.POLL_GAP(PG), .MAX_POLLS(MP)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .lba_i(lba_i),
        .cmd_i(cmd_i), .mode_i(mode_i), .done_o(done_o), .fault_o(fault_o),
        .absent_o(absent_o), .dev_addr_o(dev_addr_o), .dev_wr_o(dev_wr_o),
        .dev_wdata_o(dev_wdata_o), .dev_rd_o(dev_rd_o), .dev_rdata_i(dev_rdata_i)
    );

    // ---------------- device model ----------------
    int          m_mode;
    int          pre_busy, post_busy;
    bit          df_busy, df_idle, cmd_seen;
    int          wr_n, rd_total;
    logic [3:0]  wa [8];
    logic [15:0] wd [8];

    function automatic bit is_pk(input int m);
        return (m == 1) || (m == 3);
    endfunction
    function automatic logic [3:0] sts_at(input int m);
        return is_pk(m) ? 4'd6 : ((m == 2) ? 4'd14 : 4'd7);
    endfunction

    always @(posedge clk) begin
        logic [7:0] st;
        if (dev_wr_o) begin
            if (wr_n < 8) begin
                wa[wr_n] = dev_addr_o;
                wd[wr_n] = dev_wdata_o;
            end
            wr_n++;
            if (dev_addr_o == sts_at(m_mode)) cmd_seen = 1'b1;
        end
        if (dev_rd_o) begin
            rd_total++;
            if (!cmd_seen) begin
                if (pre_busy > 0) begin st = 8'h80; pre_busy--; end
                else st = 8'h50;
            end else begin
                if (post_busy > 0) begin
                    st = df_busy ? 8'hA0 : 8'h80;
                    post_busy--;
                end else begin
                    st = df_idle ? 8'h68 : 8'h48;
                end
            end
            if (dev_addr_o != sts_at(m_mode)) dev_rdata_i <= 16'hFFFF;
            else if (is_pk(m_mode))           dev_rdata_i <= {st, 8'hA5};
            else                              dev_rdata_i <= {8'hA5, st};
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    int          en;
    logic [3:0]  ea [8];
    logic [15:0] ed [8];

    task automatic build_exp(input int m, input logic [27:0] lba, input logic [7:0] cmd);
        logic [7:0] v [6];
        v[0] = 8'h01; v[1] = lba[7:0]; v[2] = lba[15:8]; v[3] = lba[23:16];
        v[4] = {4'hE, lba[27:24]}; v[5] = cmd;
        if (is_pk(m)) begin
            en = 3;
            ea[0] = 4'd2; ed[0] = {lba[7:0], 8'h01};
            ea[1] = 4'd4; ed[1] = {lba[23:16], lba[15:8]};
            ea[2] = 4'd6; ed[2] = {cmd, 4'hE, lba[27:24]};
        end else begin
            en = 6;
            for (int i = 0; i < 6; i++) begin
                ea[i] = (m == 2) ? 4'(2 * (i + 2)) : 4'(i + 2);
                ed[i] = {8'h00, v[i]};
            end
        end
    endtask

    // Set up the model and present a request (caller is at a negedge)
    task automatic launch(input int m, input logic [27:0] lba, input logic [7:0] cmd,
                          input int pb, input int qb, input bit dfb, input bit dfi);
        m_mode = m; pre_busy = pb; post_busy = qb; df_busy = dfb; df_idle = dfi;
        cmd_seen = 1'b0; wr_n = 0;
        build_exp(m, lba, cmd);
        mode_i = 2'(m); lba_i = lba; cmd_i = cmd; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // Wait for the outcome from negedge 0 after acceptance; judge it
    task automatic finish(input string req, input int kind, input int lat, input bit poke);
        int k = 0;
        while (!(done_o | fault_o | absent_o) && k < 5000) begin
            @(negedge clk);
            k++;
            if (poke && k == 2) begin start_i = 1'b1; lba_i = ~lba_i; end
            if (poke && k == 3) start_i = 1'b0;
        end
        chk(k < 5000, "R8", "outcome seen", k, lat);
        chk(done_o == (kind == 0) && fault_o == (kind == 1) && absent_o == (kind == 2),
            req, "outcome kind", {done_o, fault_o, absent_o}, kind);
        chk(k == lat, "R8", "outcome latency", k, lat);
        if (kind == 2) begin
            chk(wr_n == 0, "R3", "writes when absent", wr_n, 0);
        end else begin
            chk(wr_n == en, req, "write count", wr_n, en);
            for (int i = 0; i < en && i < wr_n; i++) begin
                chk(wa[i] == ea[i], req, "write address", wa[i], ea[i]);
                chk(wd[i] == ed[i], req, "write data", wd[i], ed[i]);
            end
        end
    endtask

    function automatic int lat_of(input int m, input int pb, input int qb, input bit dfb);
        int w = is_pk(m) ? 3 : 6;
        if (pb >= MP) return (MP - 1) * PER + 2;
        if (dfb && qb > 0) return pb * PER + 2 + w + 2;
        return pb * PER + 2 + w + qb * PER + 2;
    endfunction

    task automatic run(input string req, input int m, input logic [27:0] lba,
                       input logic [7:0] cmd, input int pb, input int qb,
                       input bit dfb, input bit dfi, input bit poke);
        int kind = (pb >= MP) ? 2 : ((dfb && qb > 0) ? 1 : 0);
        int rd0;
        launch(m, lba, cmd, pb, qb, dfb, dfi);
        finish(req, kind, lat_of(m, pb, qb, dfb), poke);
        @(negedge clk);
        chk(!(done_o | fault_o | absent_o), "R8", "pulse one cycle", 1, 0);
        rd0 = rd_total;
        repeat (3) @(negedge clk);
        chk(rd_total == rd0 && !dev_wr_o, "R9", "idle after outcome", rd_total - rd0, 0);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL R8 watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        logic [27:0] lbas [2];
        logic [7:0]  cmds [3];
        string       rq;
        lbas[0] = 28'h0000000; lbas[1] = 28'hABCDEF1;
        cmds[0] = 8'h20; cmds[1] = 8'h30; cmds[2] = 8'hEC;
        m_mode = 0; pre_busy = 0; post_busy = 0; wr_n = 0; rd_total = 0;
        cmd_seen = 1'b0; df_busy = 1'b0; df_idle = 1'b0;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(!done_o && !fault_o && !absent_o, "R1", "outcomes in reset",
            {done_o, fault_o, absent_o}, 0);
        chk(!dev_rd_o && !dev_wr_o, "R1", "strobes in reset", {dev_rd_o, dev_wr_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done_o && !fault_o && !absent_o && !dev_rd_o && !dev_wr_o, "R1",
            "outputs after reset", {done_o, fault_o, absent_o, dev_rd_o, dev_wr_o}, 0);

        // R2, R4, R5, R6, R7: sweep modes, busy lengths, commands, addresses
        for (int m = 0; m < 4; m++)
            for (int pb = 0; pb < 3; pb++)
                for (int qi = 0; qi < 3; qi++)
                    for (int c = 0; c < 3; c++)
                        for (int a = 0; a < 2; a++) begin
                            rq = is_pk(m) ? "R6" : ((m == 2) ? "R5" : "R4");
                            run(rq, m, lbas[a] ^ 28'(pb * 28'h1111111), cmds[c],
                                pb, (qi == 2) ? 3 : qi, 1'b0, 1'b0, 1'b0);
                        end

        // R3: presence window boundary, per mode
        for (int m = 0; m < 3; m++) begin
            run("R3", m, 28'h1234567, 8'h20, MP, 0, 1'b0, 1'b0, 1'b0);
            run("R2", m, 28'h7654321, 8'h30, MP - 1, 1, 1'b0, 1'b0, 1'b0);
        end

        // R7: fault while busy, and fault bit with busy clear
        for (int m = 0; m < 3; m++) begin
            run("R7", m, 28'h0F0F0F0, 8'hEC, 1, 1, 1'b1, 1'b0, 1'b0);
            run("R7", m, 28'h0F0F0F0, 8'h20, 0, 2, 1'b1, 1'b0, 1'b0);
            run("R7", m, 28'h5555555, 8'h30, 0, 1, 1'b0, 1'b1, 1'b0);
        end

        // R9: start pulsed mid-request is ignored
        for (int m = 0; m < 3; m++)
            run("R9", m, 28'h2468ACE, 8'h20, 1, 1, 1'b0, 1'b0, 1'b1);

        // R9: start in the outcome cycle is accepted
        launch(0, 28'h1357BDF, 8'h30, 0, 1, 1'b0, 1'b0);
        finish("R9", 0, lat_of(0, 0, 1, 1'b0), 1'b0);
        launch(1, 28'h0ACE135, 8'hEC, 1, 0, 1'b0, 1'b0);
        finish("R9", 0, lat_of(1, 1, 0, 1'b0), 1'b0);
        @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule